// File: doc/BRIEF.md
# Interrupt Acceptance Gate at Instruction Boundaries

This block decides when a CPU core may divert to an external interrupt. It keeps the global interrupt-enable bit and changes it only when a jump instruction reports a 2-bit enable-control field. It considers a pending request only in the cycle in which an instruction completes. It accepts the request only if the instruction that just finished is flagged interruptible and the enable bit is already set.

An instruction that is not interruptible carries the mask over its own boundary, so the request waits for the next interruptible completion. No instruction is ever split. Once the block accepts a request, it runs a short sequence. First it asks the stack for a write of the program counter captured at the accepting boundary. Then it asks the core to load the handler address supplied on the vector input. Each request is held until its ready input answers. An acknowledge pulse goes back to the interrupt source when the address load completes. The request line is expected to stay high until that pulse.

Top module: `irq_boundary_ctrl`

## Requirements
- R1: After reset the enable bit is 0, the block is idle, and stack-write valid, PC-load valid, acknowledge and reserved-mode flag are all 0.
- R2: On a jump-mode strobe, code 2'b01 sets the enable bit and code 2'b10 clears it; code 2'b00 leaves it as it was; the new value shows on `irq_en` from the next cycle.
- R3: Code 2'b11 leaves the enable bit unchanged and drives `rsvd_mode` high for exactly the following cycle.
- R4: A request is accepted only in a cycle with `insn_done`=1, `insn_intok`=1, `irq_en`=1, `irq_req`=1 and the block idle; a completion with `insn_intok`=0 is never an acceptance point.
- R5: A request that was masked by a non-interruptible completion is accepted at the next completion that is interruptible.
- R6: The cycle after acceptance, `stk_wr_vld` is 1 with `stk_wr_data` equal to `pc_in` at the accepting cycle; both hold unchanged until a cycle with `stk_wr_rdy`=1.
- R7: After the stack handshake, `pc_ld_vld` is 1 from the next cycle, with `pc_ld_addr` equal to `vec_in` sampled in the stack-handshake cycle, held until `pc_ld_rdy`=1.
- R8: `irq_ack` is 1 exactly in the cycle in which `pc_ld_vld` and `pc_ld_rdy` are both 1, and 0 in every other cycle.
- R9: While a sequence is running, completions and requests start no new sequence; after the load handshake the block is idle in the next cycle, and stack-write valid and PC-load valid are never high together.
- R10: While the enable bit is 0 no request is accepted, whatever the completion flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_done | input | 1 | Strobe: an instruction completes this cycle |
| insn_intok | input | 1 | Completing instruction is interruptible |
| jmp_vld | input | 1 | Strobe: a jump reports its enable-control field |
| jmp_mode | input | 2 | Enable-control field (00 keep, 01 set, 10 clear, 11 reserved) |
| irq_req | input | 1 | Level-held external interrupt request |
| pc_in | input | PC_W | Current program counter |
| vec_in | input | PC_W | Handler address from external logic |
| stk_wr_vld | output | 1 | Stack write request |
| stk_wr_data | output | PC_W | Program counter to push |
| stk_wr_rdy | input | 1 | Stack write accepted |
| pc_ld_vld | output | 1 | PC load request |
| pc_ld_addr | output | PC_W | Handler address to load |
| pc_ld_rdy | input | 1 | PC load accepted |
| irq_ack | output | 1 | One-cycle acknowledge to the interrupt source |
| irq_en | output | 1 | Current global enable state |
| rsvd_mode | output | 1 | One-cycle flag for a reserved enable-control code |
| irq_busy | output | 1 | An interrupt sequence is in progress |

## Verification
The hardest case to reach is a request that stays pending while the mask is carried over a non-interruptible completion. The model must then see it accepted at exactly the next interruptible boundary and not earlier. A second hard case is a completion that arrives during a stalled stack write, which must not start a second sequence. The stimulus builds both cases directly: it sets the enable, holds the request, and issues completions with the interruptible flag low and then high. It withholds both ready inputs for several cycles and fires completions during the stall. A long run of random strobes, modes and ready patterns follows, compared cycle by cycle against a behavioural model.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PUSH = 2'd1,
      ST_VEC  = 2'd2
   } take_st_e;

   localparam logic [1:0] JM_KEEP = 2'b00;
   localparam logic [1:0] JM_ON   = 2'b01;
   localparam logic [1:0] JM_OFF  = 2'b10;
   localparam logic [1:0] JM_RSVD = 2'b11;
endpackage

// File: rtl/irq_en_ctl.sv
module irq_en_ctl
   import irq_gate_pkg::*;
#(
   parameter int MODE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              jmp_vld,
   input  logic [MODE_W-1:0] jmp_mode,
   output logic              en,
   output logic              rsvd
);
   initial begin
      if (MODE_W != 2) $error("irq_en_ctl: MODE_W must be 2");
   end

   logic en_d;

   always_comb begin
      en_d = en;
      if (jmp_vld) begin
         case (jmp_mode)
            JM_ON:   en_d = 1'b1;
            JM_OFF:  en_d = 1'b0;
            default: en_d = en;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en   <= 1'b0;
         rsvd <= 1'b0;
      end else begin
         en   <= en_d;
         rsvd <= jmp_vld && (jmp_mode == JM_RSVD);
      end
   end

   assert_rsvd_keeps_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp_vld && jmp_mode == JM_RSVD) |=> (rsvd && en == $past(en)));

   assert_set_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp_vld && jmp_mode == JM_ON) |=> en);

   assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp_vld && jmp_mode == JM_OFF) |=> !en);
endmodule

// File: rtl/irq_take_fsm.sv
module irq_take_fsm
   import irq_gate_pkg::*;
#(
   parameter int PC_W        = 16,
   parameter bit VEC_CAPTURE = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            take,
   input  logic [PC_W-1:0] pc_in,
   input  logic [PC_W-1:0] vec_in,
   input  logic            stk_rdy,
   input  logic            ld_rdy,
   output logic            stk_vld,
   output logic [PC_W-1:0] stk_data,
   output logic            ld_vld,
   output logic [PC_W-1:0] ld_addr,
   output logic            ack,
   output logic            idle
);
   take_st_e        st_q, st_d;
   logic [PC_W-1:0] pc_q;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE: if (take)    st_d = ST_PUSH;
         ST_PUSH: if (stk_rdy) st_d = ST_VEC;
         ST_VEC:  if (ld_rdy)  st_d = ST_IDLE;
         default:              st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= ST_IDLE;
         pc_q <= '0;
      end else begin
         st_q <= st_d;
         if (st_q == ST_IDLE && take) pc_q <= pc_in;
      end
   end

   generate
      if (VEC_CAPTURE) begin : g_vec_reg
         logic [PC_W-1:0] vec_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                      vec_q <= '0;
            else if (st_q == ST_PUSH && stk_rdy) vec_q <= vec_in;
         end
         assign ld_addr = vec_q;
      end else begin : g_vec_thru
         assign ld_addr = vec_in;
      end
   endgenerate

   assign idle     = (st_q == ST_IDLE);
   assign stk_vld  = (st_q == ST_PUSH);
   assign stk_data = pc_q;
   assign ld_vld   = (st_q == ST_VEC);
   assign ack      = ld_vld && ld_rdy;

   assert_push_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_vld && !stk_rdy) |=> (stk_vld && $stable(stk_data)));

   assert_push_to_vec_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (stk_vld && stk_rdy) |=> ld_vld);

   assert_load_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_vld && !ld_rdy) |=> ld_vld);

   assert_ack_then_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (idle && !stk_vld && !ld_vld));

   assert_one_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({stk_vld, ld_vld}));
endmodule

// File: rtl/irq_boundary_ctrl.sv
module irq_boundary_ctrl
   import irq_gate_pkg::*;
#(
   parameter int PC_W        = 16,
   parameter int MODE_W      = 2,
   parameter bit VEC_CAPTURE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              insn_done,
   input  logic              insn_intok,
   input  logic              jmp_vld,
   input  logic [MODE_W-1:0] jmp_mode,
   input  logic              irq_req,
   input  logic [PC_W-1:0]   pc_in,
   input  logic [PC_W-1:0]   vec_in,
   output logic              stk_wr_vld,
   output logic [PC_W-1:0]   stk_wr_data,
   input  logic              stk_wr_rdy,
   output logic              pc_ld_vld,
   output logic [PC_W-1:0]   pc_ld_addr,
   input  logic              pc_ld_rdy,
   output logic              irq_ack,
   output logic              irq_en,
   output logic              rsvd_mode,
   output logic              irq_busy
);
   initial begin
      if (PC_W < 2 || PC_W > 64) $error("irq_boundary_ctrl: PC_W out of range");
   end

   logic idle;
   logic boundary_ok;
   logic take;

   assign boundary_ok = insn_done && insn_intok;
   assign take        = boundary_ok && irq_en && irq_req && idle;
   assign irq_busy    = !idle;

   irq_en_ctl #(.MODE_W(MODE_W)) u_en (
      .clk      (clk),
      .rst_n    (rst_n),
      .jmp_vld  (jmp_vld),
      .jmp_mode (jmp_mode),
      .en       (irq_en),
      .rsvd     (rsvd_mode)
   );

   irq_take_fsm #(.PC_W(PC_W), .VEC_CAPTURE(VEC_CAPTURE)) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .take     (take),
      .pc_in    (pc_in),
      .vec_in   (vec_in),
      .stk_rdy  (stk_wr_rdy),
      .ld_rdy   (pc_ld_rdy),
      .stk_vld  (stk_wr_vld),
      .stk_data (stk_wr_data),
      .ld_vld   (pc_ld_vld),
      .ld_addr  (pc_ld_addr),
      .ack      (irq_ack),
      .idle     (idle)
   );

   assert_masked_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && insn_done && !insn_intok) |=> !stk_wr_vld);

   assert_need_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && !irq_en) |=> !stk_wr_vld);

   assert_busy_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_ld_vld && !pc_ld_rdy) |=> !stk_wr_vld);
endmodule

// File: tb/irq_boundary_ctrl_bench.sv
`timescale 1ns/1ps
module irq_boundary_ctrl_bench;
   localparam int PC_W = 16;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            insn_done = 0, insn_intok = 0, jmp_vld = 0, irq_req = 0;
   logic [1:0]      jmp_mode = 2'b00;
   logic [PC_W-1:0] pc_in = '0, vec_in = '0;
   logic            stk_wr_rdy = 0, pc_ld_rdy = 0;
   logic            stk_wr_vld, pc_ld_vld, irq_ack, irq_en, rsvd_mode, irq_busy;
   logic [PC_W-1:0] stk_wr_data, pc_ld_addr;

   int vectors = 0;
   int fails   = 0;
   int cyc     = 0;

   // behavioural reference state
   int              m_st = 0;   // 0 idle, 1 pushing, 2 loading
   bit              m_en = 0, m_rsvd = 0;
   logic [PC_W-1:0] m_pc = '0, m_vec = '0;

   always #10 clk = ~clk;

   irq_boundary_ctrl #(.PC_W(PC_W)) u_irq_boundary_ctrl (
      .clk(clk), .rst_n(rst_n), .insn_done(insn_done), .insn_intok(insn_intok),
      .jmp_vld(jmp_vld), .jmp_mode(jmp_mode), .irq_req(irq_req),
      .pc_in(pc_in), .vec_in(vec_in),
      .stk_wr_vld(stk_wr_vld), .stk_wr_data(stk_wr_data), .stk_wr_rdy(stk_wr_rdy),
      .pc_ld_vld(pc_ld_vld), .pc_ld_addr(pc_ld_addr), .pc_ld_rdy(pc_ld_rdy),
      .irq_ack(irq_ack), .irq_en(irq_en), .rsvd_mode(rsvd_mode), .irq_busy(irq_busy)
   );

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_en = 0; m_rsvd = 0; m_pc = '0; m_vec = '0;
      end else begin
         m_rsvd = jmp_vld && jmp_mode == 2'b11;
         case (m_st)
            0: if (insn_done && insn_intok && m_en && irq_req) begin
                  m_st = 1; m_pc = pc_in;
               end
            1: if (stk_wr_rdy) begin m_st = 2; m_vec = vec_in; end
            default: if (pc_ld_rdy) m_st = 0;
         endcase
         if (jmp_vld && jmp_mode == 2'b01) m_en = 1;
         if (jmp_vld && jmp_mode == 2'b10) m_en = 0;
      end
   end

   task automatic chk(input string tag, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s cycle %0d: actual %h expected %h", tag, cyc, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R2/R10 irq_en", {15'd0, irq_en}, {15'd0, m_en});
      chk("R3 rsvd_mode", {15'd0, rsvd_mode}, {15'd0, m_rsvd});
      chk("R4/R5 stk_wr_vld", {15'd0, stk_wr_vld}, {15'd0, m_st == 1});
      if (m_st == 1) chk("R6 stk_wr_data", stk_wr_data, m_pc);
      chk("R7 pc_ld_vld", {15'd0, pc_ld_vld}, {15'd0, m_st == 2});
      if (m_st == 2) chk("R7 pc_ld_addr", pc_ld_addr, m_vec);
      chk("R8 irq_ack", {15'd0, irq_ack}, {15'd0, (m_st == 2) && pc_ld_rdy});
      chk("R9 irq_busy", {15'd0, irq_busy}, {15'd0, m_st != 0});
   endtask

   task automatic step(input bit d, input bit ok, input bit jv, input logic [1:0] jm,
                       input bit rq, input bit sr, input bit lr);
      @(negedge clk);
      cyc++;
      insn_done = d; insn_intok = ok; jmp_vld = jv; jmp_mode = jm;
      irq_req = rq; stk_wr_rdy = sr; pc_ld_rdy = lr;
      pc_in  = PC_W'(cyc * 3 + 16'h0100);
      vec_in = PC_W'(16'hA000 ^ cyc);
      #1;
      compare_all();
   endtask

   initial begin
      #2_000_000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1 irq_en", {15'd0, irq_en}, 16'd0);
      chk("R1 stk_wr_vld", {15'd0, stk_wr_vld}, 16'd0);
      chk("R1 pc_ld_vld", {15'd0, pc_ld_vld}, 16'd0);
      chk("R1 irq_ack", {15'd0, irq_ack}, 16'd0);
      chk("R1 rsvd_mode", {15'd0, rsvd_mode}, 16'd0);
      rst_n = 1'b1;

      // R10: disabled, interruptible completions with request held
      step(1,1,0,2'b00,1,1,1); step(1,1,0,2'b00,1,1,1); step(0,0,0,2'b00,1,1,1);
      // R2: enable with a keep-code strobe in between
      step(0,0,1,2'b01,0,0,0); step(0,0,1,2'b00,0,0,0);
      // R4/R5: non-interruptible completion masks, next interruptible takes
      step(1,0,0,2'b00,1,0,0); step(0,0,0,2'b00,1,0,0); step(1,1,0,2'b00,1,0,0);
      // R6: stalled push, with completions arriving (R9)
      step(1,1,0,2'b00,1,0,0); step(1,1,0,2'b00,1,0,0); step(0,0,0,2'b00,1,1,0);
      // R7/R8: stalled load, then handshake
      step(1,1,0,2'b00,1,0,0); step(0,0,0,2'b00,1,0,0); step(0,0,0,2'b00,1,0,1);
      step(0,0,0,2'b00,0,0,0);
      // R3: reserved code keeps enable, flags one cycle
      step(0,0,1,2'b11,0,0,0); step(0,0,0,2'b00,0,0,0);
      // R2/R10: disable, then offered boundary is refused
      step(0,0,1,2'b10,0,0,0); step(1,1,1,2'b11,1,1,1); step(1,1,0,2'b00,1,1,1);
      // back-to-back take with immediate ready
      step(0,0,1,2'b01,1,1,1); step(1,1,0,2'b00,1,1,1); step(0,0,0,2'b00,1,1,1);
      step(0,0,0,2'b00,1,1,1); step(0,0,0,2'b00,0,1,1);

      // random stretch
      for (int i = 0; i < 4000; i++) begin
         automatic logic [3:0] r = 4'($urandom);
         step(r[0], 1'($urandom), (($urandom % 5) == 0), 2'($urandom), r[1] | r[2],
              1'($urandom), 1'($urandom));
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end
endmodule